// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block sits behind the control port of a video controller and interprets every 16-bit word the host writes there. A word can do one of two things. It can load one of the controller's transfer registers: the auto-increment step, the two bytes of the DMA length, or the three bytes of the DMA source. It can also form half of a two-word access command. The two halves of a command together build a 16-bit target address and a 6-bit access code. Between the halves, a pending flag records that the second word is still owed.

When a completed command asks for DMA, the block decides whether the transfer starts at once. The decision uses the mode field in the top two bits of the source-high byte. A transfer that starts from external memory also raises a bus-hold request toward the host CPU. Both the run and the hold stay active until the DMA engine reports completion. A status word reports the state of the write FIFO and of the DMA. The DMA datapath and the video memories are outside this block. They consume its register, address and code outputs.

Top module: `vcmd_port_decoder`

## Requirements
- R1: Reset is synchronous and active low. Afterwards the pending flag, address, code, DMA run, bus hold, auto-increment, DMA length and DMA source all read zero.
- R2: With no command pending, a control word whose bits 15:14 are 2'b10 is a register write. Bits 13:8 give the index and bits 7:0 give the value, visible one cycle later. Index 15 loads the auto-increment. Index 19 loads the length low byte and index 20 the length high byte. Indices 21, 22 and 23 load the source low, middle and high bytes.
- R3: With no command pending, any other control word is a first command word. Its bits 13:0 replace address bits 13:0 and its bits 15:14 replace code bits 1:0. The pending flag is then set.
- R4: With a command pending, a control word is the second command word. Its bits 1:0 replace address bits 15:14 and its bits 7:4 replace code bits 5:2. The pending flag is then cleared.
- R5: When a second word carries code bit 5 (word bit 7) and the source mode field (source-high bits 7:6) is not 2'b10, DMA run is set on the next cycle. With mode 2'b10, the word does not start DMA.
- R6: On such a start, bus hold is set when source-high bit 7 is clear and cleared when it is set. Bus hold is never active without DMA run.
- R7: A dma_done pulse clears DMA run and bus hold on the next cycle, unless a DMA start occurs in the same cycle, in which case the start wins.
- R8: The status word carries fifo_full in bit 8 and DMA run in bit 5. All other bits are zero.
- R9: A data-port write or a status read, in a cycle without a control write, clears the pending flag. The next control word is then decoded as a fresh first word or register write.
- R10: A register write to any index other than 15 and 19 to 23 changes no register.
- R11: A second command word whose bits 15:14 are 2'b10 is still taken as a command word. It changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_wdata | input | 16 | Control-port write word |
| data_wr | input | 1 | Data-port write strobe, used to drop a pending command |
| stat_rd | input | 1 | Status read strobe, used to drop a pending command |
| fifo_full | input | 1 | Write FIFO full indication |
| dma_done | input | 1 | DMA engine completion pulse |
| stat_word | output | 16 | Status word |
| cmd_addr | output | 16 | Assembled target address |
| cmd_code | output | 6 | Assembled access code |
| cmd_pending | output | 1 | Second command word awaited |
| dma_run | output | 1 | DMA transfer active |
| bus_hold | output | 1 | Bus request toward the host CPU for external transfers |
| auto_inc | output | 8 | Auto-increment step |
| dma_len | output | 16 | DMA length |
| dma_src | output | 24 | DMA source; bits 23:22 are the mode field |

## Verification
The hardest situation to reach is a DMA start landing in the same cycle as a dma_done pulse. It needs a pending command, a non-fill mode already programmed into source-high, and the completion pulse aligned with the second word. The bench builds that state with a register write and a first word, then drives the second word and dma_done together. The cases where the pending flag is dropped by a data write or status read are also brought about on purpose. Each is followed by a word with bits 15:14 set to 2'b10, to show it is decoded as a register write rather than a second half.

// File: rtl/vcd_pkg.sv
// Package: shared constants and types of the command port decoder.
// Assumes a 16-bit control word; register indices are 6 bits wide.
package vcd_pkg;
    localparam int CTL_W     = 16;
    localparam int ADDR_W    = 16;
    localparam int CODE_W    = 6;
    localparam int IDX_W     = 6;
    localparam int BYTE_W    = 8;
    localparam int LEN_BYTES = 2;
    localparam int SRC_BYTES = 3;
    localparam int LEN_W     = LEN_BYTES * BYTE_W;
    localparam int SRC_W     = SRC_BYTES * BYTE_W;

    // register indices whose positions the host software relies on
    localparam logic [IDX_W-1:0] IDX_AUTOINC = 6'd15;
    localparam logic [IDX_W-1:0] IDX_LEN_LO  = 6'd19;
    localparam logic [IDX_W-1:0] IDX_SRC_LO  = 6'd21;

    localparam logic [1:0] REG_TAG   = 2'b10;  // top bits marking a register write
    localparam logic [1:0] MODE_FILL = 2'b10;  // source mode that defers start

    localparam int STAT_FULL_BIT = 8;
    localparam int STAT_DMA_BIT  = 5;
    localparam int CODE_DMA_BIT  = 7;          // word bit that becomes code bit 5

    typedef enum logic [1:0] {
        WK_NONE   = 2'd0,
        WK_REG    = 2'd1,
        WK_FIRST  = 2'd2,
        WK_SECOND = 2'd3
    } word_kind_e;
endpackage

// File: rtl/vcd_word_class.sv
// Module: classifies a control-port word by pending state and top bits.
// Assumes ctl_wr is a one-cycle strobe; purely combinational.
module vcd_word_class
    import vcd_pkg::*;
(
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              pending,
    output word_kind_e        kind,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [BYTE_W-1:0] reg_val
);
    // Pick the meaning of the incoming word.
    always_comb begin
        if (!ctl_wr)
            kind = WK_NONE;
        else if (pending)
            kind = WK_SECOND;
        else if (ctl_wdata[CTL_W-1 -: 2] == REG_TAG)
            kind = WK_REG;
        else
            kind = WK_FIRST;
    end

    assign reg_idx = ctl_wdata[BYTE_W +: IDX_W];
    assign reg_val = ctl_wdata[BYTE_W-1:0];
endmodule

// File: rtl/vcd_regfile.sv
// Module: transfer register file (auto-increment, DMA length, DMA source).
// Assumes byte-wide writes; unknown indices are dropped silently.
module vcd_regfile
    import vcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] val,
    output logic [BYTE_W-1:0] auto_inc,
    output logic [LEN_W-1:0]  dma_len,
    output logic [SRC_W-1:0]  dma_src
);
    // Load the auto-increment step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            auto_inc <= '0;
        else if (we && idx == IDX_AUTOINC)
            auto_inc <= val;
    end

    for (genvar g = 0; g < LEN_BYTES; g++) begin : g_len
        localparam logic [IDX_W-1:0] MY_IDX = IDX_LEN_LO + IDX_W'(g);
        // Load one byte of the DMA length.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dma_len[g*BYTE_W +: BYTE_W] <= '0;
            else if (we && idx == MY_IDX)
                dma_len[g*BYTE_W +: BYTE_W] <= val;
        end
    end

    for (genvar g = 0; g < SRC_BYTES; g++) begin : g_src
        localparam logic [IDX_W-1:0] MY_IDX = IDX_SRC_LO + IDX_W'(g);
        // Load one byte of the DMA source.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dma_src[g*BYTE_W +: BYTE_W] <= '0;
            else if (we && idx == MY_IDX)
                dma_src[g*BYTE_W +: BYTE_W] <= val;
        end
    end
endmodule

// File: rtl/vcd_cmd_track.sv
// Module: assembles address and access code from the two command words.
// Assumes a control write outranks a clear request in the same cycle.
module vcd_cmd_track
    import vcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  word_kind_e        kind,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              clr_req,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CODE_W-1:0] cmd_code,
    output logic              pending
);
    localparam int LO_ADDR = ADDR_W - 2;

    // Update address, code and pending flag per word kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_addr <= '0;
            cmd_code <= '0;
            pending  <= 1'b0;
        end else begin
            unique case (kind)
                WK_FIRST: begin
                    cmd_addr[LO_ADDR-1:0] <= ctl_wdata[LO_ADDR-1:0];
                    cmd_code[1:0]         <= ctl_wdata[CTL_W-1 -: 2];
                    pending               <= 1'b1;
                end
                WK_SECOND: begin
                    cmd_addr[ADDR_W-1:LO_ADDR] <= ctl_wdata[1:0];
                    cmd_code[CODE_W-1:2]       <= ctl_wdata[7:4];
                    pending                    <= 1'b0;
                end
                WK_REG: ;
                default: if (clr_req) pending <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/vcd_dma_launch.sv
// Module: decides DMA start on the second command word and holds run/bus-hold.
// Assumes the engine pulses dma_done once per transfer; a start wins over it.
module vcd_dma_launch
    import vcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       second_word,
    input  logic       dma_req,
    input  logic [1:0] src_mode,
    input  logic       dma_done,
    output logic       dma_run,
    output logic       bus_hold
);
    logic start;

    // A start needs the DMA code bit and any mode except fill.
    always_comb start = second_word && dma_req && (src_mode != MODE_FILL);

    // Track run and hold until completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_run  <= 1'b0;
            bus_hold <= 1'b0;
        end else if (start) begin
            dma_run  <= 1'b1;
            bus_hold <= !src_mode[1];
        end else if (dma_done) begin
            dma_run  <= 1'b0;
            bus_hold <= 1'b0;
        end
    end
endmodule

// File: rtl/vcmd_port_decoder.sv
// Module: top of the control-port decoder; wires classifier, register file,
// command tracker and DMA launcher, and builds the status word.
// Assumes all strobes are synchronous to clk.
module vcmd_port_decoder
    import vcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              data_wr,
    input  logic              stat_rd,
    input  logic              fifo_full,
    input  logic              dma_done,
    output logic [15:0]       stat_word,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CODE_W-1:0] cmd_code,
    output logic              cmd_pending,
    output logic              dma_run,
    output logic              bus_hold,
    output logic [BYTE_W-1:0] auto_inc,
    output logic [LEN_W-1:0]  dma_len,
    output logic [SRC_W-1:0]  dma_src
);
    word_kind_e        kind;
    logic [IDX_W-1:0]  reg_idx;
    logic [BYTE_W-1:0] reg_val;

    vcd_word_class u_class (
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .pending   (cmd_pending),
        .kind      (kind),
        .reg_idx   (reg_idx),
        .reg_val   (reg_val)
    );

    vcd_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (kind == WK_REG),
        .idx      (reg_idx),
        .val      (reg_val),
        .auto_inc (auto_inc),
        .dma_len  (dma_len),
        .dma_src  (dma_src)
    );

    vcd_cmd_track u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .ctl_wdata (ctl_wdata),
        .clr_req   (data_wr || stat_rd),
        .cmd_addr  (cmd_addr),
        .cmd_code  (cmd_code),
        .pending   (cmd_pending)
    );

    vcd_dma_launch u_dma (
        .clk         (clk),
        .rst_n       (rst_n),
        .second_word (kind == WK_SECOND),
        .dma_req     (ctl_wdata[CODE_DMA_BIT]),
        .src_mode    (dma_src[SRC_W-1 -: 2]),
        .dma_done    (dma_done),
        .dma_run     (dma_run),
        .bus_hold    (bus_hold)
    );

    // Assemble the status word.
    always_comb begin
        stat_word                = '0;
        stat_word[STAT_FULL_BIT] = fifo_full;
        stat_word[STAT_DMA_BIT]  = dma_run;
    end
endmodule

// File: rtl/vcd_checker.sv
// Module: property checker for the command port decoder, bound to the top.
module vcd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_wr,
    input logic [15:0] ctl_wdata,
    input logic        data_wr,
    input logic        stat_rd,
    input logic        fifo_full,
    input logic        dma_done,
    input logic [15:0] stat_word,
    input logic [15:0] cmd_addr,
    input logic        cmd_pending,
    input logic        dma_run,
    input logic        bus_hold,
    input logic [7:0]  auto_inc,
    input logic [15:0] dma_len,
    input logic [23:0] dma_src
);
    logic known_idx;
    always_comb known_idx = (ctl_wdata[13:8] == 6'd15) ||
                            (ctl_wdata[13:8] >= 6'd19 && ctl_wdata[13:8] <= 6'd23);

    a_r3_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !cmd_pending && ctl_wdata[15:14] != 2'b10
        |=> cmd_pending && cmd_addr[13:0] == $past(ctl_wdata[13:0]));

    a_r4_second_word: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && cmd_pending
        |=> !cmd_pending && cmd_addr[15:14] == $past(ctl_wdata[1:0]));

    a_r5_dma_start: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && cmd_pending && ctl_wdata[7] && dma_src[23:22] != 2'b10 |=> dma_run);

    a_r5_fill_defers: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && cmd_pending && dma_src[23:22] == 2'b10 && !dma_run |=> !dma_run);

    a_r6_hold_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |-> dma_run);

    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done && !(ctl_wr && cmd_pending) |=> !dma_run && !bus_hold);

    a_r8_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[8] == fifo_full && stat_word[5] == dma_run && $countones(stat_word) <= 2);

    a_r9_drop_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr && (data_wr || stat_rd) |=> !cmd_pending);

    a_r10_unknown_index: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !cmd_pending && ctl_wdata[15:14] == 2'b10 && !known_idx
        |=> $stable(auto_inc) && $stable(dma_len) && $stable(dma_src));

    a_r11_second_not_reg: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && cmd_pending
        |=> $stable(auto_inc) && $stable(dma_len) && $stable(dma_src));
endmodule

bind vcmd_port_decoder vcd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .data_wr     (data_wr),
    .stat_rd     (stat_rd),
    .fifo_full   (fifo_full),
    .dma_done    (dma_done),
    .stat_word   (stat_word),
    .cmd_addr    (cmd_addr),
    .cmd_pending (cmd_pending),
    .dma_run     (dma_run),
    .bus_hold    (bus_hold),
    .auto_inc    (auto_inc),
    .dma_len     (dma_len),
    .dma_src     (dma_src)
);

// File: tb/tb_vcmd_port_decoder.sv
`timescale 1ns/1ps
module tb_vcmd_port_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        data_wr = 1'b0;
    logic        stat_rd = 1'b0;
    logic        fifo_full = 1'b0;
    logic        dma_done = 1'b0;
    logic [15:0] stat_word;
    logic [15:0] cmd_addr;
    logic [5:0]  cmd_code;
    logic        cmd_pending;
    logic        dma_run;
    logic        bus_hold;
    logic [7:0]  auto_inc;
    logic [15:0] dma_len;
    logic [23:0] dma_src;

    always #2.5 clk = ~clk;

    vcmd_port_decoder dut (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    int m_addr, m_code, m_pend, m_run, m_hold, m_ai, m_len, m_src;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // reference model step on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_code = 0; m_pend = 0; m_run = 0; m_hold = 0;
            m_ai = 0; m_len = 0; m_src = 0;
        end else begin
            int w;
            int idx;
            bit go;
            w  = int'(ctl_wdata);
            go = 0;
            if (ctl_wr) begin
                if (m_pend != 0) begin
                    m_addr = (m_addr & 'h3FFF) | ((w & 3) << 14);
                    m_code = (m_code & 3) | (((w >> 4) & 'hF) << 2);
                    m_pend = 0;
                    if (((w >> 7) & 1) != 0 && ((m_src >> 22) & 3) != 2) begin
                        go = 1;
                        m_run = 1;
                        m_hold = (((m_src >> 23) & 1) == 0) ? 1 : 0;
                    end
                end else if (((w >> 14) & 3) == 2) begin
                    idx = (w >> 8) & 63;
                    case (idx)
                        15: m_ai = w & 255;
                        19: m_len = (m_len & 'hFF00) | (w & 255);
                        20: m_len = (m_len & 'h00FF) | ((w & 255) << 8);
                        21: m_src = (m_src & 'hFFFF00) | (w & 255);
                        22: m_src = (m_src & 'hFF00FF) | ((w & 255) << 8);
                        23: m_src = (m_src & 'h00FFFF) | ((w & 255) << 16);
                        default: ;
                    endcase
                end else begin
                    m_addr = (m_addr & 'hC000) | (w & 'h3FFF);
                    m_code = (m_code & 'h3C) | ((w >> 14) & 3);
                    m_pend = 1;
                end
            end else if (data_wr || stat_rd) begin
                m_pend = 0;
            end
            if (dma_done && !go) begin
                m_run = 0;
                m_hold = 0;
            end
        end
    end

    // compare with the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int es;
            es = (fifo_full ? 'h100 : 0) | ((m_run != 0) ? 'h20 : 0);
            chk(int'(cmd_addr) == m_addr, "R3/R4 address", int'(cmd_addr), m_addr);
            chk(int'(cmd_code) == m_code, "R3/R4 code", int'(cmd_code), m_code);
            chk(int'(cmd_pending) == m_pend, "R3 pending", int'(cmd_pending), m_pend);
            chk(int'(dma_run) == m_run, "R5 dma_run", int'(dma_run), m_run);
            chk(int'(bus_hold) == m_hold, "R6 bus_hold", int'(bus_hold), m_hold);
            chk(int'(stat_word) == es, "R8 status", int'(stat_word), es);
            chk(int'(auto_inc) == m_ai, "R2 auto_inc", int'(auto_inc), m_ai);
            chk(int'(dma_len) == m_len, "R2 dma_len", int'(dma_len), m_len);
            chk(int'(dma_src) == m_src, "R2 dma_src", int'(dma_src), m_src);
        end
    end

    task automatic wr_ctl(input logic [15:0] w, input bit done_too = 0);
        @(posedge clk); #1;
        ctl_wr = 1; ctl_wdata = w; dma_done = done_too;
        @(posedge clk); #1;
        ctl_wr = 0; dma_done = 0;
        @(negedge clk);
    endtask

    task automatic pulse_done();
        @(posedge clk); #1; dma_done = 1;
        @(posedge clk); #1; dma_done = 0;
        @(negedge clk);
    endtask

    task automatic pulse_data();
        @(posedge clk); #1; data_wr = 1;
        @(posedge clk); #1; data_wr = 0;
        @(negedge clk);
    endtask

    task automatic pulse_stat();
        @(posedge clk); #1; stat_rd = 1;
        @(posedge clk); #1; stat_rd = 0;
        @(negedge clk);
    endtask

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_pending == 0 && dma_run == 0 && bus_hold == 0, "R1 flags", int'(cmd_pending), 0);
        chk(cmd_addr == 0 && cmd_code == 0, "R1 command", int'(cmd_addr), 0);
        chk(auto_inc == 0 && dma_len == 0 && dma_src == 0, "R1 registers", int'(dma_src), 0);

        // R2 register writes
        wr_ctl(16'h8F02);
        wr_ctl(16'h9334);
        wr_ctl(16'h9412);
        wr_ctl(16'h9556);
        wr_ctl(16'h9678);
        wr_ctl(16'h9700);
        chk(auto_inc == 8'h02, "R2 auto_inc", int'(auto_inc), 'h02);
        chk(dma_len == 16'h1234, "R2 dma_len", int'(dma_len), 'h1234);
        chk(dma_src == 24'h007856, "R2 dma_src", int'(dma_src), 'h007856);

        // R10 unknown indices
        wr_ctl(16'h8011);
        wr_ctl(16'h9099);
        wr_ctl(16'hBFAA);
        chk(auto_inc == 8'h02 && dma_len == 16'h1234, "R10 ignored", int'(dma_len), 'h1234);
        chk(dma_src == 24'h007856, "R10 ignored src", int'(dma_src), 'h007856);

        // R3 / R4 plain command
        wr_ctl(16'h4123);
        chk(cmd_pending == 1 && cmd_addr[13:0] == 14'h0123, "R3 first word", int'(cmd_addr), 'h0123);
        chk(cmd_code == 6'h01, "R3 code low", int'(cmd_code), 'h01);
        wr_ctl(16'h0003);
        chk(cmd_pending == 0 && cmd_addr == 16'hC123, "R4 second word", int'(cmd_addr), 'hC123);
        chk(dma_run == 0, "R5 no DMA bit", int'(dma_run), 0);

        // R5 / R6 external transfer, mode 00
        wr_ctl(16'h4000);
        wr_ctl(16'h0080);
        chk(cmd_code == 6'h21, "R4 code DMA", int'(cmd_code), 'h21);
        chk(dma_run == 1 && bus_hold == 1, "R6 hold external", int'(bus_hold), 1);
        chk(stat_word == 16'h0020, "R8 status busy", int'(stat_word), 'h20);
        pulse_done();
        chk(dma_run == 0 && bus_hold == 0, "R7 done", int'(dma_run), 0);

        // R8 fifo full
        @(posedge clk); #1 fifo_full = 1;
        @(negedge clk);
        chk(stat_word == 16'h0100, "R8 status full", int'(stat_word), 'h100);
        @(posedge clk); #1 fifo_full = 0;

        // R5 fill mode defers
        wr_ctl(16'h9780);
        wr_ctl(16'h4000);
        wr_ctl(16'h0080);
        chk(dma_run == 0, "R5 fill no start", int'(dma_run), 0);

        // R6 copy mode: run without hold
        wr_ctl(16'h97C0);
        wr_ctl(16'h4000);
        wr_ctl(16'h0080);
        chk(dma_run == 1 && bus_hold == 0, "R6 copy no hold", int'(bus_hold), 0);
        pulse_done();

        // R6 mode 01 external
        wr_ctl(16'h9740);
        wr_ctl(16'h4000);
        wr_ctl(16'h0080);
        chk(dma_run == 1 && bus_hold == 1, "R6 mode01 hold", int'(bus_hold), 1);
        pulse_done();
        chk(dma_run == 0 && bus_hold == 0, "R7 done mode01", int'(bus_hold), 0);

        // R9 data write drops pending
        wr_ctl(16'h4000);
        pulse_data();
        chk(cmd_pending == 0, "R9 data clears", int'(cmd_pending), 0);
        wr_ctl(16'h8F07);
        chk(auto_inc == 8'h07, "R9 then register", int'(auto_inc), 'h07);

        // R9 status read drops pending
        wr_ctl(16'h4000);
        pulse_stat();
        chk(cmd_pending == 0, "R9 stat clears", int'(cmd_pending), 0);
        wr_ctl(16'h8F09);
        chk(auto_inc == 8'h09, "R9 stat then register", int'(auto_inc), 'h09);

        // R11 register-looking second word
        wr_ctl(16'h4000);
        wr_ctl(16'h8F55);
        chk(auto_inc == 8'h09, "R11 no reg write", int'(auto_inc), 'h09);
        chk(cmd_addr == 16'h4000 && cmd_code == 6'h15, "R11 taken as command", int'(cmd_code), 'h15);
        chk(cmd_pending == 0, "R11 pending cleared", int'(cmd_pending), 0);

        // R7 start wins over done in the same cycle
        wr_ctl(16'h9700);
        wr_ctl(16'h4000);
        wr_ctl(16'h0080, 1);
        chk(dma_run == 1 && bus_hold == 1, "R7 start wins", int'(dma_run), 1);
        pulse_done();
        chk(dma_run == 0, "R7 final done", int'(dma_run), 0);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule